// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of several masters owns a shared multipoint bus. Every master raises its own request bit, and the requests merge into one shared request line. From that line the controller only knows that some master wants the bus, not which one. When the bus is idle and a request is pending, the controller launches a single grant token into position 0 of a chain of device slots. Each slot either keeps the token, when its master is requesting, or hands it to the next slot one clock later. Position 0 therefore has the highest priority and position N-1 the lowest.

The slot that keeps the token raises its master-active output, which also drives the shared busy line. It holds the bus for as long as its request stays high. While busy is high the controller launches nothing. If the token leaves the far end of the chain with no taker, the controller becomes idle again and launches a fresh token when a request is next seen. The block is meant to sit beside a bus fabric that uses the master-active bits to pick its driver.

Top module: `daisy_arb_top`

## Requirements
- R1: `bus_req` is high in exactly those cycles in which at least one bit of `dev_req` is high, with no register delay, and this also holds during reset.
- R2: With the bus idle, the controller launches a grant token one clock edge after it sees a request. The token reaches slot k k edges later, so if the request vector is applied just before edge E0, slot k becomes master on edge E(k+1). At most one token is ever in the chain.
- R3: Among the slots that request when the token passes, the one with the lowest index takes it. No slot with a higher index ever becomes master from that token.
- R4: At most one `dev_master` bit is high in any cycle, and `bus_busy` is high exactly when one of them is.
- R5: A master keeps its `dev_master` bit and `bus_busy` high while its request stays high. On the first edge that samples its request low, it drops both in the same cycle.
- R6: While `bus_busy` is high, no new token is launched and a new request from any slot, including a higher-priority one, does not change the current master.
- R7: If the token passes the last slot untaken, the controller withdraws it. It launches a new token on the second edge after the token leaves the chain, provided a request is still pending, so that an untaken token costs N+3 extra edges.
- R8: A synchronous active-high `rst` clears the token chain, all `dev_master` bits and `bus_busy`, whatever the request inputs are.
- R9: After a master releases the bus on edge C, with another request pending, slot k becomes master on edge C+k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dev_req | input | N_DEV | Per-slot bus request; bit 0 has the highest priority |
| dev_master | output | N_DEV | Per-slot master-active flag |
| bus_busy | output | 1 | Shared busy line, high while any slot is master |
| bus_req | output | 1 | Shared request line, OR of all requests |

## Verification
A wrong state in the token chain shows up at the ports within N edges. A dropped token appears as a missing master rise, so the scoreboard finds the expected winner absent at the expected edge. A duplicated token appears as a second master bit or a lower-priority winner. A controller stuck in its waiting or holding state shows up as a request that is never served. A launch made too early or too late shows up as a winner arriving at the wrong cycle, because every expected rise carries an exact cycle number. Release faults appear on the first edge after a request drops, as `dev_master` or `bus_busy` left high.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_WAIT = 2'd1,
        CTL_HOLD = 2'd2
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e state;
        logic       grant;
    } ctl_reg_t;

    typedef struct packed {
        logic master;
        logic pass;
    } slot_reg_t;

endpackage

// File: rtl/daisy_arb_ctrl.sv
module daisy_arb_ctrl
    import daisy_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_req,
    input  logic bus_busy,
    input  logic in_flight,
    output logic head_grant
);

    ctl_reg_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.grant = 1'b0;
        case (r_q.state)
            CTL_IDLE: begin
                if (bus_req && !bus_busy) begin
                    r_d.grant = 1'b1;
                    r_d.state = CTL_WAIT;
                end
            end
            CTL_WAIT: begin
                if (bus_busy) begin
                    r_d.state = CTL_HOLD;
                end else if (!in_flight) begin
                    r_d.state = CTL_IDLE;
                end
            end
            CTL_HOLD: begin
                if (!bus_busy) begin
                    r_d.state = CTL_IDLE;
                end
            end
            default: r_d.state = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= CTL_IDLE;
            r_q.grant <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign head_grant = r_q.grant;

    // R6
    no_grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
        bus_busy |=> !head_grant);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        head_grant |=> !head_grant);

endmodule

// File: rtl/daisy_arb_slot.sv
module daisy_arb_slot
    import daisy_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic grant_in,
    output logic grant_out,
    output logic master
);

    slot_reg_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.pass = 1'b0;
        if (s_q.master) begin
            s_d.master = req;
        end else if (grant_in) begin
            if (req) begin
                s_d.master = 1'b1;
            end else begin
                s_d.pass = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.master <= 1'b0;
            s_q.pass   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_out = s_q.pass;
    assign master    = s_q.master;

    // R3
    take_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(master) |-> $past(grant_in));

    // R3
    grant_consumed_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_in && !master) |=> (grant_out != master));

    // R5
    hold_while_req_chk: assert property (@(posedge clk) disable iff (rst)
        (master && req) |=> master);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (master && !req) |=> !master);

endmodule

// File: rtl/daisy_arb_top.sv
module daisy_arb_top #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] dev_req,
    output logic [N_DEV-1:0] dev_master,
    output logic             bus_busy,
    output logic             bus_req
);

    localparam int CHAIN_LEN = N_DEV + 1;

    logic [CHAIN_LEN-1:0] grant_chain;
    logic                 in_flight;

    assign bus_req   = |dev_req;
    assign bus_busy  = |dev_master;
    assign in_flight = |grant_chain;

    daisy_arb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_req    (bus_req),
        .bus_busy   (bus_busy),
        .in_flight  (in_flight),
        .head_grant (grant_chain[0])
    );

    for (genvar g = 0; g < N_DEV; g++) begin : g_slot
        daisy_arb_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .req       (dev_req[g]),
            .grant_in  (grant_chain[g]),
            .grant_out (grant_chain[g+1]),
            .master    (dev_master[g])
        );
    end

    // R4
    one_master_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_master));

    // R2
    one_token_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_chain));

    // R6
    no_token_while_owned_chk: assert property (@(posedge clk) disable iff (rst)
        bus_busy |-> (grant_chain[0] == 1'b0));

endmodule

// File: tb/daisy_arb_top_tb.sv
module daisy_arb_top_tb;

    localparam int N = 4;

    typedef struct {
        int idx;
        int cyc;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] dev_master;
    logic         bus_busy;
    logic         bus_req;

    int   checks = 0;
    int   errors = 0;
    int   cyc    = 0;
    exp_t sb[$];
    logic [N-1:0] prev_master = '0;

    daisy_arb_top #(.N_DEV(N)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .dev_req    (dev_req),
        .dev_master (dev_master),
        .bus_busy   (bus_busy),
        .bus_req    (bus_req)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int idx, input int at);
        exp_t e;
        e.idx = idx;
        e.cyc = at;
        sb.push_back(e);
    endtask

    function automatic int idx_of(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    // monitor: compares each new master against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            logic [N-1:0] rises;
            rises = dev_master & ~prev_master;
            chk($countones(dev_master) <= 1, "R4 one master", $countones(dev_master), 1);
            chk(bus_busy == (dev_master != 0), "R4 busy", bus_busy, dev_master != 0);
            if (rises != 0) begin
                if (sb.size() == 0) begin
                    chk(0, "R3 unexpected master", idx_of(rises), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(idx_of(rises) == e.idx, "R3 winner", idx_of(rises), e.idx);
                    chk(cyc == e.cyc, "R2 grant latency", cyc, e.cyc);
                end
            end
        end
        prev_master = dev_master;
    end

    // driver: request from idle, expect lowest index at cyc+idx+2 (R2, R3)
    task automatic arb(input logic [N-1:0] req, input int exp_idx);
        @(negedge clk);
        dev_req = req;
        push(exp_idx, cyc + exp_idx + 2);
        wait (sb.size() == 0);
    endtask

    task automatic drop_all();
        @(negedge clk);
        dev_req = '0;
        @(negedge clk);
        chk(dev_master == 0, "R5 release master", dev_master, 0);
        chk(bus_busy == 0, "R5 release busy", bus_busy, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c;
        // R8: reset holds everything clear even with requests present
        dev_req = '1;
        repeat (3) @(negedge clk);
        chk(dev_master == 0, "R8 reset master", dev_master, 0);
        chk(bus_busy == 0, "R8 reset busy", bus_busy, 0);
        chk(bus_req == 1, "R1 req OR in reset", bus_req, 1);
        dev_req = '0;
        rst = 1'b0;
        @(negedge clk);
        chk(bus_req == 0, "R1 req OR idle", bus_req, 0);
        repeat (2) @(negedge clk);

        // R2 R3: several patterns
        arb(4'b0001, 0);
        // R5: held while request high
        repeat (4) @(negedge clk);
        chk(dev_master == 4'b0001 && bus_busy, "R5 hold", dev_master, 1);
        drop_all();
        arb(4'b1000, 3);
        drop_all();
        arb(4'b0110, 1);
        drop_all();
        arb(4'b1111, 0);
        drop_all();

        // R6: no preemption by a higher-priority request
        arb(4'b0100, 2);
        @(negedge clk);
        dev_req = 4'b0101;
        chk(bus_req == 1, "R1 req OR", bus_req, 1);
        repeat (4) @(negedge clk);
        chk(dev_master == 4'b0100, "R6 no preempt", dev_master, 4'b0100);
        // R9: release with slot 0 waiting
        c = cyc;
        dev_req = 4'b0001;
        push(0, c + 4);
        @(negedge clk);
        chk(dev_master == 0 && !bus_busy, "R5 release edge", dev_master, 0);
        wait (sb.size() == 0);
        drop_all();

        // R7: token passes the end untaken, then re-issued
        @(negedge clk);
        c = cyc;
        dev_req = 4'b0010;
        @(negedge clk);
        @(negedge clk);
        dev_req = 4'b0001;
        push(0, c + 9);
        wait (sb.size() == 0);
        drop_all();

        // R9 at a deeper slot
        arb(4'b0010, 1);
        @(negedge clk);
        c = cyc;
        dev_req = 4'b1000;
        push(3, c + 7);
        wait (sb.size() == 0);
        drop_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule